// File: doc/BRIEF.md
# Warp Divergence Mask Unit

This block holds the control state of one group of 32 lanes that run in lockstep under a single shared program counter. A mask records which lanes take part in the current instruction. When a launch begins a group, the block builds the starting mask from the number of valid threads, so the unused tail lanes of a short final group never run. Lane i of group w carries thread 32*w+i. Each group keeps its own copy of this state.

The issue logic reports one retired instruction per cycle: a plain step, a conditional branch with a per-lane taken vector, or an exit by a set of lanes. A branch on which every active lane agrees only moves the program counter. A branch that splits the lanes pushes an entry onto a reconvergence stack and runs the taken lanes first. When the program counter reaches the reconvergence address, or when every lane of the running path has exited, the block spends one settling cycle and switches to the not-taken lanes at their pending address. When that path reaches the same point, it takes a second settling cycle and restores the mask the group had before the branch. Lanes that have exited stay out of every restored mask. The group is finished once no lane is active and the stack is empty.

Top module: `warp_div_unit`

## Requirements
- R1: After reset, pc is 0, active_mask is 0, depth is 0, overflow and settling are 0 and done is 1.
- R2: A cycle with launch high sets pc to launch_pc, sets active_mask bit i (lane i) for every i below launch_count and clears the other bits, clears depth, the exited lanes and overflow, and ignores op in that cycle.
- R3: op = 1 (step) increments pc by one and leaves active_mask and depth unchanged. op = 0 changes nothing.
- R4: op = 2 (branch) uses only taken bits of active lanes. If all active lanes are taken, pc becomes br_target. If none are taken, pc is incremented. In both cases active_mask and depth stay unchanged.
- R5: A branch whose active taken bits are a proper nonempty subset of active_mask sets pc to br_target, sets active_mask to those taken lanes and raises depth by one.
- R6: When depth > 0 and pc equals the top entry's reconvergence address, settling is 1. The first such cycle loads pc with the branch address plus one and active_mask with the untaken lanes. The second such cycle loads pc with the reconvergence address, active_mask with the pre-branch mask, and lowers depth by one.
- R7: When depth > 0 and active_mask is 0, settling is 1 and the block switches paths as in R6, whatever the pc.
- R8: op = 3 (exit) clears the active bits named in exit_lanes and increments pc. An exited lane stays out of every mask restored from the stack until the next launch.
- R9: In a cycle where settling is 1 and launch is 0, op and its operands have no effect.
- R10: A splitting branch while depth equals DEPTH (8) sets overflow and leaves pc, active_mask and depth unchanged. overflow stays set until the next launch.
- R11: done is 1 exactly when active_mask is 0 and depth is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| launch | input | 1 | Start a new group |
| launch_pc | input | 16 | Start address |
| launch_count | input | 6 | Number of valid lanes, 0 to 32 |
| op | input | 2 | 0 idle, 1 step, 2 branch, 3 exit |
| taken | input | 32 | Per-lane branch outcome |
| br_target | input | 16 | Branch destination |
| br_reconv | input | 16 | Reconvergence address of the branch |
| exit_lanes | input | 32 | Lanes retiring in an exit |
| pc | output | 16 | Shared program counter |
| active_mask | output | 32 | Lanes enabled for the current instruction |
| depth | output | 4 | Stack entries in use |
| settling | output | 1 | Path switch in progress; op ignored |
| done | output | 1 | No lane active and stack empty |
| overflow | output | 1 | Sticky stack overflow |

## Verification
A fault in the stored pending address, pending mask or saved mask stays hidden until the pc reaches the reconvergence address, which can be many cycles after the branch. It shows only in the cycle after settling rises, as a wrong pc or active_mask. Stimulus therefore uses short, nearby reconvergence targets, so that most branches unwind within a few steps, including nested and zero-length paths. A stale exited set or a wrong stack pointer shows as a revived lane or a wrong depth in the same cycle it is used. Every output is compared against a requirement-level model on every cycle.

// File: rtl/warp_div_pkg.sv
package warp_div_pkg;
  typedef enum logic [1:0] {
    OP_IDLE   = 2'd0,
    OP_STEP   = 2'd1,
    OP_BRANCH = 2'd2,
    OP_EXIT   = 2'd3
  } warp_op_e;
endpackage

// File: rtl/warp_init_mask.sv
module warp_init_mask #(
  parameter int LANES = 32,
  localparam int CW = $clog2(LANES + 1)
) (
  input  logic [CW-1:0]    count,
  output logic [LANES-1:0] mask
);
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign mask[i] = (count > CW'(i));
  end
endmodule

// File: rtl/warp_recon_stack.sv
module warp_recon_stack #(
  parameter int LANES = 32,
  parameter int PCW   = 16,
  parameter int DEPTH = 8,
  localparam int DW = $clog2(DEPTH + 1),
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             push,
  input  logic             pop,
  input  logic             mark,
  input  logic [PCW-1:0]   in_rpc,
  input  logic [PCW-1:0]   in_ppc,
  input  logic [LANES-1:0] in_pmask,
  input  logic [LANES-1:0] in_omask,
  output logic [PCW-1:0]   top_rpc,
  output logic [PCW-1:0]   top_ppc,
  output logic [LANES-1:0] top_pmask,
  output logic [LANES-1:0] top_omask,
  output logic             top_second,
  output logic [DW-1:0]    depth,
  output logic             full,
  output logic             empty
);
  logic [PCW-1:0]   rpc_q   [DEPTH];
  logic [PCW-1:0]   ppc_q   [DEPTH];
  logic [LANES-1:0] pmask_q [DEPTH];
  logic [LANES-1:0] omask_q [DEPTH];
  logic [DEPTH-1:0] sec_q, sec_d;
  logic [DW-1:0]    sp_q, sp_d;
  logic [AW-1:0]    top_idx;

  assign empty   = (sp_q == '0);
  assign full    = (sp_q == DW'(DEPTH));
  assign depth   = sp_q;
  assign top_idx = empty ? '0 : AW'(sp_q - DW'(1));

  assign top_rpc    = rpc_q[top_idx];
  assign top_ppc    = ppc_q[top_idx];
  assign top_pmask  = pmask_q[top_idx];
  assign top_omask  = omask_q[top_idx];
  assign top_second = sec_q[top_idx];

  always_comb begin
    sp_d  = sp_q;
    sec_d = sec_q;
    if (clr) begin
      sp_d = '0;
    end else if (push) begin
      sp_d = sp_q + DW'(1);
      sec_d[AW'(sp_q)] = 1'b0;
    end else if (pop) begin
      sp_d = sp_q - DW'(1);
    end else if (mark) begin
      sec_d[top_idx] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sp_q  <= '0;
      sec_q <= '0;
    end else begin
      sp_q  <= sp_d;
      sec_q <= sec_d;
    end
  end

  for (genvar e = 0; e < DEPTH; e++) begin : g_entry
    logic wr_en;
    assign wr_en = push && !clr && (sp_q == DW'(e));
    always_ff @(posedge clk) begin
      if (wr_en) begin
        rpc_q[e]   <= in_rpc;
        ppc_q[e]   <= in_ppc;
        pmask_q[e] <= in_pmask;
        omask_q[e] <= in_omask;
      end
    end
  end

  assert_push_room_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !clr) |-> !full);
  assert_pop_filled_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !clr) |-> !empty);
endmodule

// File: rtl/warp_div_unit.sv
module warp_div_unit
  import warp_div_pkg::*;
#(
  parameter int LANES = 32,
  parameter int PCW   = 16,
  parameter int DEPTH = 8,
  localparam int CW = $clog2(LANES + 1),
  localparam int DW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             launch,
  input  logic [PCW-1:0]   launch_pc,
  input  logic [CW-1:0]    launch_count,
  input  logic [1:0]       op,
  input  logic [LANES-1:0] taken,
  input  logic [PCW-1:0]   br_target,
  input  logic [PCW-1:0]   br_reconv,
  input  logic [LANES-1:0] exit_lanes,
  output logic [PCW-1:0]   pc,
  output logic [LANES-1:0] active_mask,
  output logic [DW-1:0]    depth,
  output logic             settling,
  output logic             done,
  output logic             overflow
);
  logic [PCW-1:0]   pc_q, pc_d;
  logic [LANES-1:0] mask_q, mask_d, gone_q, gone_d;
  logic             err_q, err_d;
  logic [LANES-1:0] start_mask, tk;
  logic             st_push, st_pop, st_mark, st_full, st_empty, st_second;
  logic [PCW-1:0]   st_rpc, st_ppc;
  logic [LANES-1:0] st_pmask, st_omask;
  warp_op_e         op_e;

  assign op_e = warp_op_e'(op);
  assign tk   = taken & mask_q;

  warp_init_mask #(.LANES(LANES)) u_init (
    .count (launch_count),
    .mask  (start_mask)
  );

  warp_recon_stack #(.LANES(LANES), .PCW(PCW), .DEPTH(DEPTH)) u_stack (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr        (launch),
    .push       (st_push),
    .pop        (st_pop),
    .mark       (st_mark),
    .in_rpc     (br_reconv),
    .in_ppc     (pc_q + PCW'(1)),
    .in_pmask   (mask_q & ~tk),
    .in_omask   (mask_q),
    .top_rpc    (st_rpc),
    .top_ppc    (st_ppc),
    .top_pmask  (st_pmask),
    .top_omask  (st_omask),
    .top_second (st_second),
    .depth      (depth),
    .full       (st_full),
    .empty      (st_empty)
  );

  assign settling    = !st_empty && ((pc_q == st_rpc) || (mask_q == '0));
  assign pc          = pc_q;
  assign active_mask = mask_q;
  assign overflow    = err_q;
  assign done        = (mask_q == '0) && st_empty;

  always_comb begin
    pc_d    = pc_q;
    mask_d  = mask_q;
    gone_d  = gone_q;
    err_d   = err_q;
    st_push = 1'b0;
    st_pop  = 1'b0;
    st_mark = 1'b0;
    if (launch) begin
      pc_d   = launch_pc;
      mask_d = start_mask;
      gone_d = '0;
      err_d  = 1'b0;
    end else if (settling) begin
      if (!st_second) begin
        pc_d    = st_ppc;
        mask_d  = st_pmask & ~gone_q;
        st_mark = 1'b1;
      end else begin
        pc_d   = st_rpc;
        mask_d = st_omask & ~gone_q;
        st_pop = 1'b1;
      end
    end else begin
      case (op_e)
        OP_STEP: pc_d = pc_q + PCW'(1);
        OP_EXIT: begin
          pc_d   = pc_q + PCW'(1);
          mask_d = mask_q & ~exit_lanes;
          gone_d = gone_q | (mask_q & exit_lanes);
        end
        OP_BRANCH: begin
          if (tk == '0) begin
            pc_d = pc_q + PCW'(1);
          end else if (tk == mask_q) begin
            pc_d = br_target;
          end else if (st_full) begin
            err_d = 1'b1;
          end else begin
            st_push = 1'b1;
            pc_d    = br_target;
            mask_d  = tk;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q   <= '0;
      mask_q <= '0;
      gone_q <= '0;
      err_q  <= 1'b0;
    end else begin
      pc_q   <= pc_d;
      mask_q <= mask_d;
      gone_q <= gone_d;
      err_q  <= err_d;
    end
  end

  assert_exited_stay_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q & gone_q) == '0);
  assert_launch_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> (depth == '0) && !overflow);
  assert_uniform_no_push_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!launch && !settling && op_e == OP_BRANCH && (tk == '0 || tk == mask_q))
    |=> $stable(depth) && $stable(active_mask));
  assert_split_runs_taken_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!launch && !settling && op_e == OP_BRANCH && tk != '0 && tk != mask_q && !st_full)
    |=> (active_mask == $past(tk)) && (depth == $past(depth) + DW'(1)));
  assert_first_switch_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!launch && settling && !st_second) |=> (pc == $past(st_ppc)));
  assert_overflow_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (overflow && !launch) |=> overflow);
endmodule

// File: tb/sim_warp_div_unit.sv
module sim_warp_div_unit;
  localparam int CLK_PERIOD = 10;
  localparam int LANES = 32;
  localparam int PCW   = 16;
  localparam int DEPTH = 8;

  logic              clk, rst_n, launch;
  logic [PCW-1:0]    launch_pc, br_target, br_reconv, pc;
  logic [5:0]        launch_count;
  logic [1:0]        op;
  logic [LANES-1:0]  taken, exit_lanes, active_mask;
  logic [3:0]        depth;
  logic              settling, done, overflow;

  warp_div_unit #(.LANES(LANES), .PCW(PCW), .DEPTH(DEPTH)) u0 (
    .clk(clk), .rst_n(rst_n), .launch(launch), .launch_pc(launch_pc),
    .launch_count(launch_count), .op(op), .taken(taken), .br_target(br_target),
    .br_reconv(br_reconv), .exit_lanes(exit_lanes), .pc(pc),
    .active_mask(active_mask), .depth(depth), .settling(settling),
    .done(done), .overflow(overflow)
  );

  int n_vec = 0;
  int n_bad = 0;

  // requirement-level model state
  logic [PCW-1:0]   m_pc;
  logic [LANES-1:0] m_mask, m_gone;
  logic             m_err;
  int               m_sp;
  logic [PCW-1:0]   m_rpc [DEPTH];
  logic [PCW-1:0]   m_ppc [DEPTH];
  logic [LANES-1:0] m_pm  [DEPTH];
  logic [LANES-1:0] m_om  [DEPTH];
  logic             m_sec [DEPTH];
  string            tag;

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic m_settle();
    return (m_sp > 0) && ((m_pc == m_rpc[m_sp-1]) || (m_mask == '0));
  endfunction

  function automatic logic [LANES-1:0] first_lanes(input int n);
    logic [LANES-1:0] r = '0;
    for (int i = 0; i < LANES; i++) if (i < n) r[i] = 1'b1;
    return r;
  endfunction

  task automatic model_update();
    logic [LANES-1:0] t;
    t = taken & m_mask;
    if (launch) begin
      m_pc = launch_pc; m_mask = first_lanes(int'(launch_count));
      m_gone = '0; m_err = 1'b0; m_sp = 0; tag = "R2";
    end else if (m_settle()) begin
      tag = (m_mask == '0) ? "R7" : "R6";
      if (!m_sec[m_sp-1]) begin
        m_pc = m_ppc[m_sp-1]; m_mask = m_pm[m_sp-1] & ~m_gone; m_sec[m_sp-1] = 1'b1;
      end else begin
        m_pc = m_rpc[m_sp-1]; m_mask = m_om[m_sp-1] & ~m_gone; m_sp--;
      end
    end else begin
      case (op)
        2'd1: begin m_pc++; tag = "R3"; end
        2'd3: begin
          m_gone = m_gone | (m_mask & exit_lanes);
          m_mask = m_mask & ~exit_lanes; m_pc++; tag = "R8";
        end
        2'd2: begin
          if (t == '0) begin m_pc++; tag = "R4"; end
          else if (t == m_mask) begin m_pc = br_target; tag = "R4"; end
          else if (m_sp == DEPTH) begin m_err = 1'b1; tag = "R10"; end
          else begin
            m_rpc[m_sp] = br_reconv; m_ppc[m_sp] = m_pc + 16'd1;
            m_pm[m_sp] = m_mask & ~t; m_om[m_sp] = m_mask; m_sec[m_sp] = 1'b0;
            m_sp++; m_pc = br_target; m_mask = t; tag = "R5";
          end
        end
        default: tag = "R3";
      endcase
    end
  endtask

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_model();
    logic [63:0] a, e;
    a = {pc, active_mask, depth, settling, done, overflow, 9'd0};
    e = {m_pc, m_mask, 4'(m_sp), m_settle(), (m_mask == '0) && (m_sp == 0), m_err, 9'd0};
    chk({tag, "/R9/R11"}, a, e);
  endtask

  task automatic drive(input logic l, input logic [15:0] lpc, input int cnt, input logic [1:0] o,
                       input logic [31:0] tk, input logic [15:0] tg, input logic [15:0] rc,
                       input logic [31:0] ex);
    launch = l; launch_pc = lpc; launch_count = 6'(cnt); op = o;
    taken = tk; br_target = tg; br_reconv = rc; exit_lanes = ex;
  endtask

  task automatic tick();
    @(posedge clk);
    model_update();
    @(negedge clk);
    check_model();
  endtask

  task automatic idle_cycle(); drive(0, 0, 0, 2'd0, '0, 0, 0, '0); tick(); endtask
  task automatic step_cycle(); drive(0, 0, 0, 2'd1, '0, 0, 0, '0); tick(); endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_bad++;
    $display("FAIL R1 watchdog actual=timeout expected=finished");
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    drive(0, 0, 0, 2'd0, '0, 0, 0, '0);
    m_pc = '0; m_mask = '0; m_gone = '0; m_err = 1'b0; m_sp = 0; tag = "R1";
    for (int i = 0; i < DEPTH; i++) begin
      m_rpc[i] = '0; m_ppc[i] = '0; m_pm[i] = '0; m_om[i] = '0; m_sec[i] = 1'b0;
    end
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", {pc, active_mask, depth, settling, done, overflow}, {16'h0, 32'h0, 4'd0, 1'b0, 1'b1, 1'b0});
    rst_n = 1'b1;
    idle_cycle();

    // R2 partial final group of 5 lanes
    drive(1, 16'h0100, 5, 2'd1, '1, 0, 0, '1); tick();
    chk("R2", {pc, active_mask}, {16'h0100, 32'h0000_001F});
    step_cycle(); chk("R3", pc, 16'h0101);
    idle_cycle(); chk("R3", {pc, active_mask}, {16'h0101, 32'h1F});
    drive(0, 0, 0, 2'd2, 32'hFFFF_FFFF, 16'h0200, 16'h0300, '0); tick();
    chk("R4", {pc, active_mask, depth}, {16'h0200, 32'h1F, 4'd0});
    drive(0, 0, 0, 2'd2, 32'hFFFF_FFE0, 16'h0900, 16'h0300, '0); tick();
    chk("R4", {pc, depth}, {16'h0201, 4'd0});
    drive(0, 0, 0, 2'd2, 32'h3, 16'h0210, 16'h0212, '0); tick();
    chk("R5", {pc, active_mask, depth}, {16'h0210, 32'h3, 4'd1});
    step_cycle(); step_cycle();
    chk("R6", {pc, 3'(settling)}, {16'h0212, 3'd1});
    step_cycle();
    chk("R9", {pc, active_mask, depth}, {16'h0202, 32'h1C, 4'd1});
    repeat (16) step_cycle();
    chk("R6", {pc, 3'(settling)}, {16'h0212, 3'd1});
    idle_cycle();
    chk("R6", {pc, active_mask, depth}, {16'h0212, 32'h1F, 4'd0});
    drive(0, 0, 0, 2'd3, '0, 0, 0, 32'h1); tick();
    chk("R8", {pc, active_mask}, {16'h0213, 32'h1E});
    drive(0, 0, 0, 2'd2, 32'h6, 16'h0400, 16'h0500, '0); tick();
    drive(0, 0, 0, 2'd3, '0, 0, 0, 32'h6); tick();
    chk("R7", {active_mask, 3'(settling), 3'(done)}, {32'h0, 3'd1, 3'd0});
    idle_cycle();
    chk("R7", {pc, active_mask}, {16'h0214, 32'h18});
    drive(0, 0, 0, 2'd3, '0, 0, 0, 32'h18); tick();
    idle_cycle();
    chk("R8", {pc, active_mask, depth}, {16'h0500, 32'h0, 4'd0});
    chk("R11", 64'(done), 64'd1);

    // R10 stack overflow with a full group
    drive(1, 16'h0000, 32, 2'd0, '0, 0, 0, '0); tick();
    chk("R2", active_mask, 32'hFFFF_FFFF);
    for (int k = 0; k < DEPTH; k++) begin
      drive(0, 0, 0, 2'd2, active_mask & (active_mask - 32'd1), pc + 16'd1, 16'hF000, '0); tick();
    end
    chk("R5", {active_mask, depth}, {32'hFFFF_FF00, 4'd8});
    drive(0, 0, 0, 2'd2, 32'hFFFF_FE00, 16'h7777, 16'hF000, '0); tick();
    chk("R10", {pc, active_mask, depth, 3'(overflow)}, {16'd8, 32'hFFFF_FF00, 4'd8, 3'd1});
    step_cycle(); chk("R10", 64'(overflow), 64'd1);
    drive(1, 16'h0040, 0, 2'd0, '0, 0, 0, '0); tick();
    chk("R2", {active_mask, depth, 3'(overflow), 3'(done)}, {32'h0, 4'd0, 3'd0, 3'd1});

    // constrained random traffic with nearby reconvergence points
    void'($urandom(32'h5EED_0042));
    for (int n = 0; n < 20000; n++) begin
      int sel, kind;
      logic [31:0] tv;
      logic [15:0] tg;
      sel = int'($urandom_range(0, 99));
      if (sel < 1) begin
        drive(1, 16'($urandom), int'($urandom_range(0, 32)), 2'($urandom), $urandom, 0, 0, $urandom);
      end else if (sel < 60) begin
        drive(0, 0, 0, 2'd1, $urandom, 0, 0, $urandom);
      end else if (sel < 82) begin
        kind = int'($urandom_range(0, 3));
        tv = (kind == 0) ? '1 : (kind == 1) ? '0 : $urandom;
        tg = pc + 16'($urandom_range(1, 3));
        drive(0, 0, 0, 2'd2, tv, tg, tg + 16'($urandom_range(0, 3)), '0);
      end else if (sel < 87) begin
        drive(0, 0, 0, 2'd3, '0, 0, 0, 32'd1 << $urandom_range(0, 31));
      end else begin
        drive(0, 0, 0, 2'd0, $urandom, 16'($urandom), 16'($urandom), $urandom);
      end
      tick();
    end

    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule